// File: doc/BRIEF.md
# Unsigned Adder-Subtractor with Magnitude Result

This block is a purely combinational arithmetic unit for two unsigned operands of a parameterised width. A single mode input chooses between addition and subtraction. In add mode it returns the truncated sum and raises a carry output when the sum does not fit in the operand width. In subtract mode it never returns a wrapped two's-complement difference. It returns the magnitude of the difference, and a separate negative flag shows that the second operand was the larger one.

Only one ripple-carry adder is used for both operations. The second operand passes through a bank of XOR gates that the mode bit drives. The mode bit also feeds the adder's carry-in, so subtraction forms M + ~N + 1. In subtract mode the adder's end carry tells which operand is larger. When that carry is clear, a selective two's-complement stage corrects the raw sum: it keeps every bit up to and including the lowest set bit and inverts every bit above it. A per-bit 2-to-1 multiplexer then selects either the corrected value or the raw sum.

The block has no clock, no reset and no state. A small combinational decoder turns the mode into the selects for the multiplexer and the flags. It takes one of two named operating modes, MODE_ADD and MODE_SUB, and a new input vector moves it straight from one mode to the other.

Top module: `mag_addsub`

## Requirements
- R1: With mode_sub = 0 (MODE_ADD), result equals (opnd_m + opnd_n) modulo 2^W.
- R2: With mode_sub = 0, carry_out equals bit W of the full sum opnd_m + opnd_n.
- R3: With mode_sub = 1 (MODE_SUB) and opnd_m > opnd_n, result equals opnd_m - opnd_n and neg_flag is 0.
- R4: With mode_sub = 1 and opnd_m < opnd_n, result equals opnd_n - opnd_m and neg_flag is 1.
- R5: With mode_sub = 0, neg_flag is 0 for every pair of operands.
- R6: With mode_sub = 1, carry_out is 0 for every pair of operands.
- R7: With mode_sub = 1 and opnd_m equal to opnd_n, result is all zeros and neg_flag is 0.
- R8: At W = 8, subtracting opnd_n = 150 from opnd_m = 100 gives result 50 with neg_flag 1. Without the correction the sum would read 206.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_m | input | W | First unsigned operand (minuend in subtract mode) |
| opnd_n | input | W | Second unsigned operand (subtrahend in subtract mode) |
| mode_sub | input | 1 | 0 selects addition, 1 selects magnitude subtraction |
| result | output | W | Sum, or magnitude of the difference |
| carry_out | output | 1 | Unsigned overflow of the sum; 0 in subtract mode |
| neg_flag | output | 1 | Set in subtract mode when opnd_n exceeds opnd_m |

## Verification
The bound checker compares the ports with a wide arithmetic model whenever its inputs settle. It checks the sum and carry in add mode, the magnitude and sign in both subtract cases, and the mode-exclusive flags. The bench runs the default 4-bit width over every operand pair in both modes, which covers the all-ones, zero and equal-operand boundaries that the correction stage has to handle. The 8-bit example can only be shown by a scenario, because it needs a second instance with a wider parameter.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } mode_e;
endpackage

// File: rtl/addsub_invert.sv
module addsub_invert #(
    parameter int W = 4
) (
    input  logic [W-1:0] din,
    input  logic         flip,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_xor
        assign dout[i] = din[i] ^ flip;
    end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] cy;
    assign cy[0] = cin;
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]  = a[i] ^ b[i] ^ cy[i];
        assign cy[i+1] = (a[i] & b[i]) | (a[i] & cy[i]) | (b[i] & cy[i]);
    end
    assign cout = cy[W];
endmodule

// File: rtl/addsub_twos_fix.sv
module addsub_twos_fix #(
    parameter int W = 4
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // seen[i] is set once a 1 has appeared strictly below bit i
    logic [W:0] seen;
    assign seen[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_scan
        assign dout[i]   = din[i] ^ seen[i];
        assign seen[i+1] = seen[i] | din[i];
    end
endmodule

// File: rtl/addsub_mux.sv
module addsub_mux #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel_b,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_mux
        assign y[i] = sel_b ? b[i] : a[i];
    end
endmodule

// File: rtl/mag_addsub.sv
module mag_addsub
    import addsub_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] opnd_m,
    input  logic [W-1:0] opnd_n,
    input  logic         mode_sub,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         neg_flag
);
    mode_e        op;
    logic [W-1:0] n_cond;
    logic [W-1:0] raw_sum;
    logic [W-1:0] fixed;
    logic         end_carry;
    logic         need_fix;

    assign op = mode_e'(mode_sub);

    addsub_invert #(.W(W)) u_inv (
        .din  (opnd_n),
        .flip (mode_sub),
        .dout (n_cond)
    );

    addsub_ripple #(.W(W)) u_add (
        .a    (opnd_m),
        .b    (n_cond),
        .cin  (mode_sub),
        .sum  (raw_sum),
        .cout (end_carry)
    );

    addsub_twos_fix #(.W(W)) u_fix (
        .din  (raw_sum),
        .dout (fixed)
    );

    // Mode decoder: flags and correction select
    always_comb begin
        need_fix  = 1'b0;
        carry_out = 1'b0;
        neg_flag  = 1'b0;
        unique case (op)
            MODE_ADD: begin
                carry_out = end_carry;
            end
            MODE_SUB: begin
                need_fix = ~end_carry;
                neg_flag = ~end_carry;
            end
            default: begin
                need_fix = 1'b0;
            end
        endcase
    end

    addsub_mux #(.W(W)) u_sel (
        .a     (raw_sum),
        .b     (fixed),
        .sel_b (need_fix),
        .y     (result)
    );
endmodule

// File: rtl/mag_addsub_chk.sv
module mag_addsub_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] opnd_m,
    input logic [W-1:0] opnd_n,
    input logic         mode_sub,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         neg_flag
);
    logic [W:0] wide_sum;
    assign wide_sum = {1'b0, opnd_m} + {1'b0, opnd_n};

    always_comb begin
        if (!mode_sub) begin
            p_sum_r1: assert (result == wide_sum[W-1:0])
                else $error("p_sum_r1 violated");
            p_carry_r2: assert (carry_out == wide_sum[W])
                else $error("p_carry_r2 violated");
            p_no_neg_r5: assert (!neg_flag)
                else $error("p_no_neg_r5 violated");
        end else begin
            p_no_carry_r6: assert (!carry_out)
                else $error("p_no_carry_r6 violated");
            if (opnd_m >= opnd_n) begin
                p_pos_diff_r3: assert (result == W'(opnd_m - opnd_n) && !neg_flag)
                    else $error("p_pos_diff_r3 violated");
            end else begin
                p_neg_diff_r4: assert (result == W'(opnd_n - opnd_m) && neg_flag)
                    else $error("p_neg_diff_r4 violated");
            end
            if (opnd_m == opnd_n) begin
                p_equal_r7: assert (result == '0 && !neg_flag)
                    else $error("p_equal_r7 violated");
            end
        end
    end
endmodule

bind mag_addsub mag_addsub_chk #(.W(W)) u_chk (
    .opnd_m    (opnd_m),
    .opnd_n    (opnd_n),
    .mode_sub  (mode_sub),
    .result    (result),
    .carry_out (carry_out),
    .neg_flag  (neg_flag)
);

// File: tb/mag_addsub_tb.sv
module mag_addsub_tb;
    localparam int W = 4;
    localparam int LIM = 1 << W;

    typedef struct {
        logic [W-1:0] res;
        logic         cy;
        logic         ng;
        string        req;
        int           m;
        int           n;
        logic         s;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0] m_in = '0;
    logic [W-1:0] n_in = '0;
    logic         s_in = 1'b0;
    logic [W-1:0] res_o;
    logic         cy_o, ng_o;

    logic [7:0] m8 = '0;
    logic [7:0] n8 = '0;
    logic       s8 = 1'b0;
    logic [7:0] res8;
    logic       cy8, ng8;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    exp_t q[$];

    mag_addsub #(.W(W)) u_dut (
        .opnd_m(m_in), .opnd_n(n_in), .mode_sub(s_in),
        .result(res_o), .carry_out(cy_o), .neg_flag(ng_o)
    );

    mag_addsub #(.W(8)) u_dut8 (
        .opnd_m(m8), .opnd_n(n8), .mode_sub(s8),
        .result(res8), .carry_out(cy8), .neg_flag(ng8)
    );

    task automatic drive(input int m, input int n, input logic s);
        exp_t e;
        int sum;
        @(negedge clk);
        m_in = W'(m);
        n_in = W'(n);
        s_in = s;
        e.m = m; e.n = n; e.s = s;
        if (!s) begin
            sum   = m + n;
            e.res = W'(sum % LIM);
            e.cy  = (sum >= LIM);
            e.ng  = 1'b0;
            e.req = "R1 R2 R5";
        end else begin
            e.cy = 1'b0;
            if (m == n) begin
                e.res = '0; e.ng = 1'b0; e.req = "R7 R6";
            end else if (m > n) begin
                e.res = W'(m - n); e.ng = 1'b0; e.req = "R3 R6";
            end else begin
                e.res = W'(n - m); e.ng = 1'b1; e.req = "R4 R6";
            end
        end
        q.push_back(e);
    endtask

    // Monitor: compare one expected item per rising edge
    always @(posedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (res_o !== e.res || cy_o !== e.cy || ng_o !== e.ng) begin
                fails++;
                $display("FAIL %s m=%0d n=%0d s=%0b: got res=%0d cy=%0b ng=%0b, expected res=%0d cy=%0b ng=%0b",
                         e.req, e.m, e.n, e.s, res_o, cy_o, ng_o, e.res, e.cy, e.ng);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: zero operands in add mode (R1)
        drive(0, 0, 1'b0);
        // the 8-bit worked example (R8)
        @(negedge clk);
        m8 = 8'd100; n8 = 8'd150; s8 = 1'b1;
        #1;
        checks++;
        if (res8 !== 8'd50 || ng8 !== 1'b1 || cy8 !== 1'b0) begin
            fails++;
            $display("FAIL R8: got res=%0d ng=%0b cy=%0b, expected res=50 ng=1 cy=0", res8, ng8, cy8);
        end
        // R8 reversed: 150-100 gives 50, positive
        m8 = 8'd150; n8 = 8'd100;
        #1;
        checks++;
        if (res8 !== 8'd50 || ng8 !== 1'b0) begin
            fails++;
            $display("FAIL R8 reversed: got res=%0d ng=%0b, expected res=50 ng=0", res8, ng8);
        end
        // corner patterns first, then every pair in both modes
        drive(LIM - 1, LIM - 1, 1'b0);
        drive(LIM - 1, 1, 1'b0);
        drive(0, LIM - 1, 1'b1);
        drive(LIM - 1, 0, 1'b1);
        drive(5, 5, 1'b1);
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < LIM; m++) begin
                for (int n = 0; n < LIM; n++) begin
                    drive(m, n, s[0]);
                end
            end
        end
        wait (q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule